// File: doc/BRIEF.md
# Linked Cell List Manager

This block keeps track of which fixed-size memory cells belong to which bucket during one pass of a bucket (radix) sort. Memory is divided into cells of 16 words. The block holds a pool of free cell indices, a head and a tail pointer for every bucket, and one shared next-pointer table with one entry per cell. Every bucket's chain and the free pool live in that one table. A bucket can therefore grow to any length, up to the whole memory, without a fixed split between buckets.

A client issues one command per cycle. An allocate command takes a cell from the free pool and appends it to the end of a bucket's chain; the client asks for one whenever a bucket's staging buffer has filled and must be written out. A release command returns a consumed input cell to the pool, so the sort can proceed in place. A walk command selects a bucket. Each following step command returns one cell of that chain, from head to tail, and then reports end of list. An init command empties every bucket and rebuilds the free pool. The result of each command appears on the response outputs one clock cycle after the command is accepted.

Top module: `lcl_cell_list`

## Requirements
- R1: After reset or init, every bucket is empty and successive allocations return cells 0, 1, 2 and so on in ascending order up to NUM_CELLS-1. While in reset, rsp_valid, rsp_err and rsp_end are 0 and rsp_cell is the null value (all ones).
- R2: An allocate command (cmd_op=0) is answered in the next cycle with rsp_valid=1, rsp_err=0, rsp_end=0 and rsp_cell holding the granted cell index, which is below NUM_CELLS.
- R3: An allocate command issued while the free pool is empty answers rsp_valid=1, rsp_err=1 and rsp_cell all ones. It changes no list.
- R4: A walk of a bucket returns its cells in the order in which they were allocated to it.
- R5: Allocations interleaved across buckets do not disturb each other: each bucket's walk returns only its own cells.
- R6: A release command (cmd_op=1) with cmd_cell below NUM_CELLS answers rsp_valid=1, rsp_err=0, rsp_cell=cmd_cell, and the next allocation grants the most recently released cell. A release with cmd_cell of NUM_CELLS or above answers rsp_err=1 and changes no list.
- R7: A walk-start command (cmd_op=2) selects cmd_bucket and gives no response (rsp_valid=0). Each step command (cmd_op=3) returns the next cell with rsp_end=0. After the tail, a step answers rsp_end=1 with rsp_cell all ones, and further steps keep answering this way.
- R8: An init command (cmd_op=4) gives no response and restores the state of R1: every bucket walks empty and the next allocation returns cell 0.
- R9: A walk of a bucket that never received a cell reports end of list on its first step.
- R10: A cycle with cmd_valid=0 is followed by rsp_valid=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | 0 allocate, 1 release, 2 walk start, 3 walk step, 4 init |
| cmd_bucket | input | $clog2(NUM_BUCKETS) | Bucket for allocate and walk start |
| cmd_cell | input | $clog2(NUM_CELLS+1) | Cell index for release |
| rsp_valid | output | 1 | Response present (one cycle after the command) |
| rsp_cell | output | $clog2(NUM_CELLS+1) | Granted, released or walked cell; all ones for none |
| rsp_err | output | 1 | Free pool empty on allocate, or release index out of range |
| rsp_end | output | 1 | Walk step found no further cell |

## Verification
The hardest situation to reach from the ports is an exhausted free pool that then receives released cells, because it needs every one of the 64 cells to be handed out first. The stimulus allocates all cells into one bucket and checks that they come out in ascending order. It then checks the error response, releases two cells, and checks that they are granted back in reverse order into a fresh bucket. A walk of that bucket shows that the old links of the reused cells were cut. Interleaved allocations to two buckets, followed by walks, show that appends to a non-empty tail link correctly.

// File: rtl/lcl_pkg.sv
package lcl_pkg;
    typedef enum logic [2:0] {
        OP_ALLOC  = 3'd0,
        OP_FREE   = 3'd1,
        OP_WSTART = 3'd2,
        OP_WNEXT  = 3'd3,
        OP_INIT   = 3'd4
    } lcl_op_e;
endpackage

// File: rtl/lcl_bucket_tbl.sv
module lcl_bucket_tbl #(
    parameter int NUM_BUCKETS = 256,
    parameter int PW          = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic [$clog2(NUM_BUCKETS)-1:0] rd_bkt,
    output logic [PW-1:0]                  rd_head,
    output logic [PW-1:0]                  rd_tail,
    input  logic                           wr_head_en,
    input  logic                           wr_tail_en,
    input  logic [PW-1:0]                  wr_ptr
);
    localparam logic [PW-1:0] NULLP = {PW{1'b1}};

    typedef struct packed {
        logic [NUM_BUCKETS-1:0][PW-1:0] head;
        logic [NUM_BUCKETS-1:0][PW-1:0] tail;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (clr) begin
            tbl_d = '1;
        end else begin
            if (wr_head_en) tbl_d.head[rd_bkt] = wr_ptr;
            if (wr_tail_en) tbl_d.tail[rd_bkt] = wr_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '1;
        else        tbl_q <= tbl_d;
    end

    assign rd_head = tbl_q.head[rd_bkt];
    assign rd_tail = tbl_q.tail[rd_bkt];

    // A bucket is either empty at both ends or at neither (R5)
    assert_head_tail_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_head == NULLP) == (rd_tail == NULLP));
endmodule

// File: rtl/lcl_walker.sv
module lcl_walker #(
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [PW-1:0] load_ptr,
    input  logic          adv,
    input  logic [PW-1:0] adv_ptr,
    output logic [PW-1:0] cur
);
    localparam logic [PW-1:0] NULLP = {PW{1'b1}};

    typedef struct packed {
        logic [PW-1:0] cur;
    } walk_t;

    walk_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (clr)                          w_d.cur = NULLP;
        else if (load)                    w_d.cur = load_ptr;
        else if (adv && w_q.cur != NULLP) w_d.cur = adv_ptr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q.cur <= NULLP;
        else        w_q <= w_d;
    end

    assign cur = w_q.cur;

    // Once past the tail, stepping keeps the walk at end (R7)
    assert_end_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == NULLP && adv && !load && !clr) |=> (cur == NULLP));
endmodule

// File: rtl/lcl_cell_list.sv
module lcl_cell_list #(
    parameter int NUM_CELLS   = 64,
    parameter int NUM_BUCKETS = 256
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cmd_valid,
    input  logic [2:0]                       cmd_op,
    input  logic [$clog2(NUM_BUCKETS)-1:0]   cmd_bucket,
    input  logic [$clog2(NUM_CELLS+1)-1:0]   cmd_cell,
    output logic                             rsp_valid,
    output logic [$clog2(NUM_CELLS+1)-1:0]   rsp_cell,
    output logic                             rsp_err,
    output logic                             rsp_end
);
    import lcl_pkg::*;

    localparam int            CW    = $clog2(NUM_CELLS);
    localparam int            PW    = $clog2(NUM_CELLS + 1);
    localparam logic [PW-1:0] NULLP = {PW{1'b1}};
    localparam logic [PW-1:0] NC_P  = PW'(NUM_CELLS);

    typedef logic [NUM_CELLS-1:0][PW-1:0] chain_t;

    typedef struct packed {
        chain_t        nxt;
        logic [PW-1:0] free_head;
        logic          rsp_valid;
        logic [PW-1:0] rsp_cell;
        logic          rsp_err;
        logic          rsp_end;
    } st_t;

    function automatic chain_t init_chain();
        chain_t c;
        for (int i = 0; i < NUM_CELLS; i++)
            c[i] = (i == NUM_CELLS - 1) ? NULLP : PW'(i + 1);
        return c;
    endfunction

    st_t st_d, st_q;
    lcl_op_e op;

    logic          tb_clr, tb_wr_head, tb_wr_tail;
    logic [PW-1:0] tb_head, tb_tail, tb_wr_ptr;
    logic          wk_clr, wk_load, wk_adv;
    logic [PW-1:0] wk_cur, wk_adv_ptr;

    assign op         = lcl_op_e'(cmd_op);
    assign wk_adv_ptr = st_q.nxt[wk_cur[CW-1:0]];

    lcl_bucket_tbl #(.NUM_BUCKETS(NUM_BUCKETS), .PW(PW)) bkt_i (
        .clk(clk), .rst_n(rst_n), .clr(tb_clr), .rd_bkt(cmd_bucket),
        .rd_head(tb_head), .rd_tail(tb_tail),
        .wr_head_en(tb_wr_head), .wr_tail_en(tb_wr_tail), .wr_ptr(tb_wr_ptr)
    );

    lcl_walker #(.PW(PW)) walk_i (
        .clk(clk), .rst_n(rst_n), .clr(wk_clr), .load(wk_load),
        .load_ptr(tb_head), .adv(wk_adv), .adv_ptr(wk_adv_ptr), .cur(wk_cur)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_cell  = NULLP;
        st_d.rsp_err   = 1'b0;
        st_d.rsp_end   = 1'b0;
        tb_clr         = 1'b0;
        tb_wr_head     = 1'b0;
        tb_wr_tail     = 1'b0;
        tb_wr_ptr      = st_q.free_head;
        wk_clr         = 1'b0;
        wk_load        = 1'b0;
        wk_adv         = 1'b0;
        if (cmd_valid) begin
            case (op)
                OP_ALLOC: begin
                    st_d.rsp_valid = 1'b1;
                    if (st_q.free_head == NULLP) begin
                        st_d.rsp_err = 1'b1;
                    end else begin
                        st_d.rsp_cell  = st_q.free_head;
                        st_d.free_head = st_q.nxt[st_q.free_head[CW-1:0]];
                        st_d.nxt[st_q.free_head[CW-1:0]] = NULLP;
                        if (tb_tail == NULLP) tb_wr_head = 1'b1;
                        else st_d.nxt[tb_tail[CW-1:0]] = st_q.free_head;
                        tb_wr_tail = 1'b1;
                    end
                end
                OP_FREE: begin
                    st_d.rsp_valid = 1'b1;
                    if (cmd_cell >= NC_P) begin
                        st_d.rsp_err = 1'b1;
                    end else begin
                        st_d.rsp_cell = cmd_cell;
                        st_d.nxt[cmd_cell[CW-1:0]] = st_q.free_head;
                        st_d.free_head = cmd_cell;
                    end
                end
                OP_WSTART: wk_load = 1'b1;
                OP_WNEXT: begin
                    st_d.rsp_valid = 1'b1;
                    if (wk_cur == NULLP) begin
                        st_d.rsp_end = 1'b1;
                    end else begin
                        st_d.rsp_cell = wk_cur;
                        wk_adv        = 1'b1;
                    end
                end
                OP_INIT: begin
                    st_d.nxt       = init_chain();
                    st_d.free_head = '0;
                    tb_clr         = 1'b1;
                    wk_clr         = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.nxt       <= init_chain();
            st_q.free_head <= '0;
            st_q.rsp_valid <= 1'b0;
            st_q.rsp_cell  <= NULLP;
            st_q.rsp_err   <= 1'b0;
            st_q.rsp_end   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_cell  = st_q.rsp_cell;
    assign rsp_err   = st_q.rsp_err;
    assign rsp_end   = st_q.rsp_end;

    assert_err_null_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_cell == NULLP));

    assert_alloc_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_ALLOC && st_q.free_head == NULLP) |=> (rsp_valid && rsp_err));

    assert_cell_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && !rsp_end) |-> (rsp_cell < NC_P));

    assert_free_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_FREE && cmd_cell < NC_P) |=> (st_q.free_head == $past(cmd_cell)));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);
endmodule

// File: tb/lcl_cell_list_tb_top.sv
module lcl_cell_list_tb_top;
    localparam int  NC    = 64;
    localparam int  NB    = 256;
    localparam int  NULLV = 127;
    localparam time CLK_P = 20ns;

    localparam int A = 0, F = 1, WS = 2, WN = 3;
    localparam int NV = 15;
    localparam int V_OP [NV] = '{A, A, A, A, WS, WN, WN, WN, WN, WS, WN, WN, WS, WN, WN};
    localparam int V_BK [NV] = '{5, 9, 5, 5, 5,  0,  0,  0,  0,  9,  0,  0, 200, 0, 0};
    localparam int V_VL [NV] = '{1, 1, 1, 1, 0,  1,  1,  1,  1,  0,  1,  1,  0,  1, 1};
    localparam int V_CL [NV] = '{0, 1, 2, 3, NULLV, 0, 2, 3, NULLV, NULLV, 1, NULLV, NULLV, NULLV, NULLV};
    localparam int V_EN [NV] = '{0, 0, 0, 0, 0,  0,  0,  0,  1,  0,  0,  1,  0,  1, 1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [7:0] cmd_bucket = '0;
    logic [6:0] cmd_cell = '0;
    logic       rsp_valid, rsp_err, rsp_end;
    logic [6:0] rsp_cell;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    lcl_cell_list #(.NUM_CELLS(NC), .NUM_BUCKETS(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bucket(cmd_bucket), .cmd_cell(cmd_cell), .rsp_valid(rsp_valid),
        .rsp_cell(rsp_cell), .rsp_err(rsp_err), .rsp_end(rsp_end)
    );

    task automatic check(string req, int ev, int ec, int eerr, int eend);
        checks++;
        if (rsp_valid !== ev[0] || rsp_cell !== ec[6:0] ||
            rsp_err !== eerr[0] || rsp_end !== eend[0]) begin
            errors++;
            $display("FAIL %s: got valid=%0b cell=%0d err=%0b end=%0b, expected valid=%0b cell=%0d err=%0b end=%0b",
                     req, rsp_valid, rsp_cell, rsp_err, rsp_end, ev[0], ec, eerr[0], eend[0]);
        end
    endtask

    // Present a command at a falling edge; the response is read at the next falling edge
    task automatic cmd(int op, int bk, int cl);
        cmd_valid  = 1'b1;
        cmd_op     = op[2:0];
        cmd_bucket = bk[7:0];
        cmd_cell   = cl[6:0];
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle();
        cmd_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got running, expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", 0, NULLV, 0, 0);
        rst_n = 1'b1;
        idle();
        check("R10 idle cycle", 0, NULLV, 0, 0);

        // R2 R4 R5 R7 R9: table of interleaved appends and walks
        for (int i = 0; i < NV; i++) begin
            cmd(V_OP[i], V_BK[i], 0);
            check("R2/R4/R5/R7/R9 vector", V_VL[i], V_CL[i], 0, V_EN[i]);
        end

        cmd(4, 0, 0);
        check("R8 init gives no response", 0, NULLV, 0, 0);

        // R1: exhaust the pool into bucket 3, ascending grant order
        for (int i = 0; i < NC; i++) begin
            cmd(A, 3, 0);
            check("R1 ascending grant", 1, i, 0, 0);
        end
        cmd(A, 3, 0);
        check("R3 alloc on empty pool", 1, NULLV, 1, 0);

        cmd(F, 0, 20);
        check("R6 release 20", 1, 20, 0, 0);
        cmd(F, 0, 30);
        check("R6 release 30", 1, 30, 0, 0);
        cmd(F, 0, 64);
        check("R6 release out of range", 1, NULLV, 1, 0);
        cmd(A, 4, 0);
        check("R6 latest release first", 1, 30, 0, 0);
        cmd(A, 4, 0);
        check("R6 earlier release next", 1, 20, 0, 0);
        cmd(A, 4, 0);
        check("R3 pool empty again", 1, NULLV, 1, 0);

        cmd(WS, 4, 0);
        check("R7 walk start no response", 0, NULLV, 0, 0);
        cmd(WN, 0, 0);
        check("R4 reused walk first", 1, 30, 0, 0);
        cmd(WN, 0, 0);
        check("R4 reused walk second", 1, 20, 0, 0);
        cmd(WN, 0, 0);
        check("R4 reused walk end", 1, NULLV, 0, 1);

        cmd(4, 0, 0);
        cmd(WS, 3, 0);
        cmd(WN, 0, 0);
        check("R8 bucket empty after init", 1, NULLV, 0, 1);
        cmd(A, 3, 0);
        check("R8 grant restarts at 0", 1, 0, 0, 0);
        cmd(A, 7, 0);
        check("R1 second grant after init", 1, 1, 0, 0);
        idle();
        check("R10 idle after traffic", 0, NULLV, 0, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule